// File: doc/BRIEF.md
# Batch Event/Semaphore Update Unit

This block executes one control command that touches up to sixteen semaphore or event slots, each paired with a general register, in a single operation. A command arrives fully decoded: a mode, an update type, a repeat count, an active-slot count, sixteen slot ids, sixteen register numbers, a 32-bit threshold and a field of reserved bits. The unit keeps its own semaphore array and event array, and it reaches the general registers through one combinational read port and one write port.

When a command is accepted, the unit checks it first. A command that fails any check raises a one-cycle illegal pulse and touches nothing. A command that passes is walked one slot per cycle, in slot order. The read modes copy slot values into registers. The update modes change slots using register operands. The conditional mode updates a semaphore only when its value has reached the threshold, bumps the paired register when it does, and repeats the whole slot list a programmable number of times. A one-cycle done pulse marks the end of the command.

Top module: `evsem_batch_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `done` and `illegal` are low, `cmd_ready` is high, and every semaphore and event entry reads zero.
- R2: Mode 0 copies semaphore `id` into the paired register and mode 1 copies event `id` into it. Semaphores and events are separate arrays, so both can hold different values under the same id.
- R3: Mode 2 updates semaphores and mode 3 updates events. Update types are 0 increment, 1 decrement, 2 add register, 3 subtract register and 4 write register. The paired register is read as the operand and is never modified.
- R4: Mode 4 is the conditional update. When the semaphore value is at or above the threshold (unsigned compare), the semaphore gets the update type applied with the register as operand, and the register is incremented by one. Otherwise neither the semaphore nor the register changes.
- R5: Mode 4 makes repeat+1 passes over the slot list. All other modes make exactly one pass, whatever the repeat count is.
- R6: Slots are handled one per cycle, in slot order, starting the cycle after acceptance. `done` pulses for one cycle right after the last slot of the last pass, so for N slot accesses it is seen N+1 cycles after the accepting edge's cycle.
- R7: A command is illegal if its mode is above 4, its slot count is 0 or above 16, or its update type is above 4 (types 5 to 7 are the immediate forms and are refused).
- R8: A command is illegal if two active slots share an id, if an active id is 16 or more, if an active register number is 32 or more, or if any unused id or register entry is nonzero.
- R9: A command is illegal if any reserved bit is set.
- R10: An illegal command gives a one-cycle `illegal` pulse in the cycle after acceptance. It gives no `done` pulse, makes no slot or register access, and leaves the unit ready.
- R11: `cmd_valid` is ignored while the unit is busy. `cmd_ready` is low for the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_mode | input | 3 | Operation mode |
| cmd_upd | input | 4 | Update type |
| cmd_rep | input | 8 | Extra passes for the conditional mode |
| cmd_cnt | input | 8 | Number of active slots |
| cmd_ids | input | 128 | Slot ids, byte per slot, slot 0 in the low byte |
| cmd_regs | input | 128 | Paired register numbers, byte per slot |
| cmd_thresh | input | 32 | Conditional threshold |
| cmd_rsvd | input | 88 | Reserved, must be zero |
| rf_raddr | output | 5 | Register read address |
| rf_rdata | input | 32 | Register read data (combinational) |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write address |
| rf_wdata | output | 32 | Register write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completed pulse |
| illegal | output | 1 | Command rejected pulse |

## Verification
The bench aims at the threshold boundary: one value just below the threshold and one exactly at it. A design that compares with greater-than would skip the equal case, and one that compares with less-than would update the wrong slot. It runs several conditional passes in which each pass reads the register incremented by the pass before. An off-by-one in the pass count, or using a stale operand, changes the final semaphore value. Each validation rule is hit with a command that would otherwise write a known semaphore, so a checker that lets one rule slip leaves a visible write behind. A reversed sixteen-slot run and a command issued while the unit is busy expose slot ordering, cycle counts and any acceptance that comes too early.

// File: rtl/evsem_pkg.sv
package evsem_pkg;
  localparam int DATA_W = 32;

  localparam logic [2:0] MODE_RD_SEM = 3'd0;
  localparam logic [2:0] MODE_RD_EVT = 3'd1;
  localparam logic [2:0] MODE_UP_SEM = 3'd2;
  localparam logic [2:0] MODE_UP_EVT = 3'd3;
  localparam logic [2:0] MODE_COND   = 3'd4;

  localparam logic [3:0] UPD_INC = 4'd0;
  localparam logic [3:0] UPD_DEC = 4'd1;
  localparam logic [3:0] UPD_ADD = 4'd2;
  localparam logic [3:0] UPD_SUB = 4'd3;
  localparam logic [3:0] UPD_WR  = 4'd4;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  function automatic logic [DATA_W-1:0] apply_upd(input logic [3:0] kind,
                                                  input logic [DATA_W-1:0] cur,
                                                  input logic [DATA_W-1:0] opnd);
    logic [DATA_W-1:0] r;
    case (kind)
      UPD_INC: r = cur + 1'b1;
      UPD_DEC: r = cur - 1'b1;
      UPD_ADD: r = cur + opnd;
      UPD_SUB: r = cur - opnd;
      UPD_WR:  r = opnd;
      default: r = cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/evsem_cmd_check.sv
module evsem_cmd_check #(
  parameter int NSLOT     = 16,
  parameter int IDW       = 8,
  parameter int RNW       = 8,
  parameter int SEM_DEPTH = 16,
  parameter int NREG      = 32,
  parameter int CNTW      = 8,
  parameter int RSVW      = 88
) (
  input  logic [2:0]           mode,
  input  logic [3:0]           upd,
  input  logic [CNTW-1:0]      cnt,
  input  logic [NSLOT*IDW-1:0] ids,
  input  logic [NSLOT*RNW-1:0] regs,
  input  logic [RSVW-1:0]      rsvd,
  output logic                 ok
);
  import evsem_pkg::*;

  logic bad_field, bad_slot, dup;

  always_comb begin
    bad_field = (mode > MODE_COND) || (upd > UPD_WR) || (cnt == '0) ||
                (32'(cnt) > NSLOT) || (|rsvd);
    bad_slot  = 1'b0;
    dup       = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (i < 32'(cnt)) begin
        if (32'(ids[i*IDW +: IDW]) >= SEM_DEPTH) bad_slot = 1'b1;
        if (32'(regs[i*RNW +: RNW]) >= NREG) bad_slot = 1'b1;
        for (int j = i + 1; j < NSLOT; j++) begin
          if ((j < 32'(cnt)) && (ids[i*IDW +: IDW] == ids[j*IDW +: IDW])) dup = 1'b1;
        end
      end else begin
        if ((ids[i*IDW +: IDW] != '0) || (regs[i*RNW +: RNW] != '0)) bad_slot = 1'b1;
      end
    end
    ok = !(bad_field || bad_slot || dup);
  end
endmodule

// File: rtl/evsem_store.sv
module evsem_store #(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sel_evt,
  input  logic [IDXW-1:0]             idx,
  output logic [evsem_pkg::DATA_W-1:0] rd_data,
  input  logic                        we,
  input  logic [evsem_pkg::DATA_W-1:0] wr_data
);
  import evsem_pkg::*;

  logic [DATA_W-1:0] mem_q [2*DEPTH];
  logic [IDXW:0]     addr;

  assign addr    = {sel_evt, idx};
  assign rd_data = mem_q[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2*DEPTH; k++) mem_q[k] <= '0;
    end else if (we) begin
      mem_q[addr] <= wr_data;
    end
  end
endmodule

// File: rtl/evsem_seq.sv
module evsem_seq #(
  parameter int NSLOT     = 16,
  parameter int IDW       = 8,
  parameter int RNW       = 8,
  parameter int SEM_DEPTH = 16,
  parameter int NREG      = 32,
  parameter int CNTW      = 8,
  parameter int REPW      = 8,
  localparam int SLW  = $clog2(NSLOT),
  localparam int IDXW = $clog2(SEM_DEPTH),
  localparam int RAW  = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic                         cmd_ok,
  input  logic [2:0]                   cmd_mode,
  input  logic [3:0]                   cmd_upd,
  input  logic [REPW-1:0]              cmd_rep,
  input  logic [CNTW-1:0]              cmd_cnt,
  input  logic [NSLOT*IDW-1:0]         cmd_ids,
  input  logic [NSLOT*RNW-1:0]         cmd_regs,
  input  logic [evsem_pkg::DATA_W-1:0] cmd_thresh,
  output logic                         busy,
  output logic                         done,
  output logic                         illegal,
  output logic                         st_evt,
  output logic [IDXW-1:0]              st_idx,
  input  logic [evsem_pkg::DATA_W-1:0] st_cur,
  output logic                         st_we,
  output logic [evsem_pkg::DATA_W-1:0] st_wdata,
  output logic [RAW-1:0]               rf_addr,
  input  logic [evsem_pkg::DATA_W-1:0] rf_rdata,
  output logic                         rf_we,
  output logic [evsem_pkg::DATA_W-1:0] rf_wdata
);
  import evsem_pkg::*;

  seq_state_e           state_q, state_d;
  logic [2:0]           mode_q;
  logic [3:0]           upd_q;
  logic [REPW-1:0]      rep_q;
  logic [CNTW-1:0]      cnt_q;
  logic [NSLOT*IDW-1:0] ids_q;
  logic [NSLOT*RNW-1:0] regs_q;
  logic [DATA_W-1:0]    thr_q;
  logic [SLW-1:0]       slot_q, slot_d;
  logic [REPW-1:0]      pass_q, pass_d;
  logic                 done_d, done_q, ill_d, ill_q;
  logic                 accept, load_en, run, last_slot, last_pass, fin, hit;
  logic [IDW-1:0]       cur_id;
  logic [RNW-1:0]       cur_reg;

  assign run       = (state_q == ST_RUN);
  assign accept    = cmd_valid && !run;
  assign load_en   = accept && cmd_ok;
  assign last_slot = (CNTW'(slot_q) == cnt_q - 1'b1);
  assign last_pass = (mode_q == MODE_COND) ? (pass_q == rep_q) : 1'b1;
  assign fin       = run && last_slot && last_pass;

  // next-state process
  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    pass_d  = pass_q;
    done_d  = 1'b0;
    ill_d   = accept && !cmd_ok;
    if (load_en) begin
      state_d = ST_RUN;
      slot_d  = '0;
      pass_d  = '0;
    end else if (run) begin
      if (last_slot) begin
        slot_d = '0;
        if (last_pass) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          pass_d = pass_q + 1'b1;
        end
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      pass_q  <= '0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
      mode_q  <= '0;
      upd_q   <= '0;
      rep_q   <= '0;
      cnt_q   <= '0;
      ids_q   <= '0;
      regs_q  <= '0;
      thr_q   <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      pass_q  <= pass_d;
      done_q  <= done_d;
      ill_q   <= ill_d;
      if (load_en) begin
        mode_q <= cmd_mode;
        upd_q  <= cmd_upd;
        rep_q  <= cmd_rep;
        cnt_q  <= cmd_cnt;
        ids_q  <= cmd_ids;
        regs_q <= cmd_regs;
        thr_q  <= cmd_thresh;
      end
    end
  end

  // slot datapath
  assign cur_id  = ids_q[32'(slot_q)*IDW +: IDW];
  assign cur_reg = regs_q[32'(slot_q)*RNW +: RNW];
  assign st_idx  = cur_id[IDXW-1:0];
  assign rf_addr = cur_reg[RAW-1:0];
  assign st_evt  = (mode_q == MODE_RD_EVT) || (mode_q == MODE_UP_EVT);
  assign hit     = (st_cur >= thr_q);

  always_comb begin
    st_we    = 1'b0;
    st_wdata = apply_upd(upd_q, st_cur, rf_rdata);
    rf_we    = 1'b0;
    rf_wdata = st_cur;
    if (run) begin
      case (mode_q)
        MODE_RD_SEM, MODE_RD_EVT: rf_we = 1'b1;
        MODE_UP_SEM, MODE_UP_EVT: st_we = 1'b1;
        MODE_COND: begin
          st_we    = hit;
          rf_we    = hit;
          rf_wdata = rf_rdata + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign busy    = run;
  assign done    = done_q;
  assign illegal = ill_q;

  // R10
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |-> (state_q == ST_IDLE));
  // R6
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((state_q == ST_IDLE) && $past(state_q == ST_RUN)));
  // R5
  single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (mode_q != MODE_COND)) |-> (pass_q == '0));
  // R6
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (CNTW'(slot_q) < cnt_q));
  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fin) |=> ($stable(ids_q) && $stable(mode_q) && $stable(thr_q)));
endmodule

// File: rtl/evsem_batch_unit.sv
module evsem_batch_unit #(
  parameter int NSLOT     = 16,
  parameter int IDW       = 8,
  parameter int RNW       = 8,
  parameter int SEM_DEPTH = 16,
  parameter int NREG      = 32,
  parameter int CNTW      = 8,
  parameter int REPW      = 8,
  parameter int RSVW      = 88,
  localparam int IDXW = $clog2(SEM_DEPTH),
  localparam int RAW  = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [2:0]                   cmd_mode,
  input  logic [3:0]                   cmd_upd,
  input  logic [REPW-1:0]              cmd_rep,
  input  logic [CNTW-1:0]              cmd_cnt,
  input  logic [NSLOT*IDW-1:0]         cmd_ids,
  input  logic [NSLOT*RNW-1:0]         cmd_regs,
  input  logic [evsem_pkg::DATA_W-1:0] cmd_thresh,
  input  logic [RSVW-1:0]              cmd_rsvd,
  output logic [RAW-1:0]               rf_raddr,
  input  logic [evsem_pkg::DATA_W-1:0] rf_rdata,
  output logic                         rf_we,
  output logic [RAW-1:0]               rf_waddr,
  output logic [evsem_pkg::DATA_W-1:0] rf_wdata,
  output logic                         busy,
  output logic                         done,
  output logic                         illegal
);
  import evsem_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              cmd_ok, st_evt, st_we;
  logic [IDXW-1:0]   st_idx;
  logic [DATA_W-1:0] st_cur, st_wdata;
  logic [RAW-1:0]    rf_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  evsem_cmd_check #(
    .NSLOT(NSLOT), .IDW(IDW), .RNW(RNW), .SEM_DEPTH(SEM_DEPTH),
    .NREG(NREG), .CNTW(CNTW), .RSVW(RSVW)
  ) u_check (
    .mode(cmd_mode), .upd(cmd_upd), .cnt(cmd_cnt), .ids(cmd_ids),
    .regs(cmd_regs), .rsvd(cmd_rsvd), .ok(cmd_ok)
  );

  evsem_seq #(
    .NSLOT(NSLOT), .IDW(IDW), .RNW(RNW), .SEM_DEPTH(SEM_DEPTH),
    .NREG(NREG), .CNTW(CNTW), .REPW(REPW)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .cmd_valid(cmd_valid), .cmd_ok(cmd_ok),
    .cmd_mode(cmd_mode), .cmd_upd(cmd_upd), .cmd_rep(cmd_rep), .cmd_cnt(cmd_cnt),
    .cmd_ids(cmd_ids), .cmd_regs(cmd_regs), .cmd_thresh(cmd_thresh),
    .busy(busy), .done(done), .illegal(illegal),
    .st_evt(st_evt), .st_idx(st_idx), .st_cur(st_cur), .st_we(st_we),
    .st_wdata(st_wdata), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_wdata(rf_wdata)
  );

  evsem_store #(.DEPTH(SEM_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_int_n), .sel_evt(st_evt), .idx(st_idx),
    .rd_data(st_cur), .we(st_we), .wr_data(st_wdata)
  );

  assign cmd_ready = !busy;
  assign rf_raddr  = rf_addr;
  assign rf_waddr  = rf_addr;
endmodule

// File: tb/test_evsem_batch_unit.sv
module test_evsem_batch_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [2:0]   cmd_mode = '0;
  logic [3:0]   cmd_upd = '0;
  logic [7:0]   cmd_rep = '0;
  logic [7:0]   cmd_cnt = '0;
  logic [127:0] cmd_ids = '0;
  logic [127:0] cmd_regs = '0;
  logic [31:0]  cmd_thresh = '0;
  logic [87:0]  cmd_rsvd = '0;
  logic [4:0]   rf_raddr, rf_waddr;
  logic [31:0]  rf_rdata, rf_wdata;
  logic         rf_we, busy, done, illegal;

  logic [31:0] rf [32];
  logic        tb_we = 1'b0;
  logic [4:0]  tb_addr = '0;
  logic [31:0] tb_data = '0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    else if (tb_we) rf[tb_addr] <= tb_data;
  end

  evsem_batch_unit i_evsem_batch_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_upd(cmd_upd), .cmd_rep(cmd_rep), .cmd_cnt(cmd_cnt),
    .cmd_ids(cmd_ids), .cmd_regs(cmd_regs), .cmd_thresh(cmd_thresh), .cmd_rsvd(cmd_rsvd),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .busy(busy), .done(done), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_reg(input int a, input logic [31:0] v);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = 5'(a); tb_data = v;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic run_cmd(input logic [2:0] m, input logic [3:0] u, input logic [7:0] rep,
                         input logic [7:0] cnt, input logic [127:0] ids,
                         input logic [127:0] regs, input logic [31:0] thr,
                         input logic [87:0] rsvd, output int cyc, output bit ill);
    @(negedge clk);
    cmd_mode = m; cmd_upd = u; cmd_rep = rep; cmd_cnt = cnt; cmd_ids = ids;
    cmd_regs = regs; cmd_thresh = thr; cmd_rsvd = rsvd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (!done && !illegal && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    ill = illegal;
  endtask

  task automatic simple(input logic [2:0] m, input logic [3:0] u, input logic [7:0] rep,
                        input int id, input int r, input logic [31:0] thr);
    int c; bit il;
    run_cmd(m, u, rep, 8'd1, 128'(id), 128'(r), thr, '0, c, il);
  endtask

  task automatic read_slot(input bit evt, input int id, output logic [31:0] v);
    simple(evt ? 3'd1 : 3'd0, 4'd0, 8'd0, id, 31, 32'd0);
    @(negedge clk);
    v = rf[31];
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 illegal", 32'(illegal), 0);
    chk("R1 ready", 32'(cmd_ready), 1);
    read_slot(1'b0, 3, v); chk("R1 sem zero", v, 0);
    read_slot(1'b1, 3, v); chk("R1 evt zero", v, 0);
  endtask

  task automatic t_write_read;
    logic [127:0] ids, regs; int c; bit il; logic [31:0] v;
    ids = '0; regs = '0;
    for (int i = 0; i < 4; i++) begin
      set_reg(i + 1, 32'd100 + 32'(i));
      ids[i*8 +: 8] = 8'(i); regs[i*8 +: 8] = 8'(i + 1);
    end
    run_cmd(3'd2, 4'd4, 8'd0, 8'd4, ids, regs, 0, '0, c, il);
    chk("R6 four slot cycles", 32'(c), 5);
    chk("R3 legal", 32'(il), 0);
    for (int i = 0; i < 4; i++) begin
      read_slot(1'b0, i, v); chk("R3 write reg", v, 32'd100 + 32'(i));
    end
  endtask

  task automatic t_evt_split;
    logic [31:0] v;
    set_reg(5, 32'hABCD);
    simple(3'd3, 4'd4, 8'd0, 0, 5, 0);
    read_slot(1'b1, 0, v); chk("R2 event read", v, 32'hABCD);
    read_slot(1'b0, 0, v); chk("R2 sem separate", v, 32'd100);
  endtask

  task automatic t_types;
    logic [31:0] v;
    set_reg(6, 32'd7);
    simple(3'd2, 4'd4, 8'd0, 4, 6, 0); read_slot(1'b0, 4, v); chk("R3 wr", v, 7);
    simple(3'd2, 4'd0, 8'd0, 4, 6, 0); read_slot(1'b0, 4, v); chk("R3 inc", v, 8);
    simple(3'd2, 4'd1, 8'd0, 4, 6, 0); read_slot(1'b0, 4, v); chk("R3 dec", v, 7);
    simple(3'd2, 4'd2, 8'd0, 4, 6, 0); read_slot(1'b0, 4, v); chk("R3 add", v, 14);
    simple(3'd2, 4'd3, 8'd0, 4, 6, 0); read_slot(1'b0, 4, v); chk("R3 sub", v, 7);
    chk("R3 register untouched", rf[6], 7);
  endtask

  task automatic t_cond;
    logic [31:0] v; int c; bit il; logic [127:0] ids, regs;
    set_reg(20, 32'd10);
    simple(3'd2, 4'd4, 8'd0, 5, 20, 0);
    set_reg(20, 32'd7);
    simple(3'd4, 4'd2, 8'd0, 5, 20, 32'd12);
    read_slot(1'b0, 5, v); chk("R4 below threshold sem", v, 10);
    chk("R4 below threshold reg", rf[20], 7);
    run_cmd(3'd4, 4'd2, 8'd2, 8'd1, 128'd5, 128'd20, 32'd10, '0, c, il);
    chk("R5 three passes cycles", 32'(c), 4);
    @(negedge clk);
    chk("R4 reg incremented per pass", rf[20], 10);
    read_slot(1'b0, 5, v); chk("R5 chained passes", v, 34);
    set_reg(21, 32'd19); set_reg(22, 32'd20);
    ids = {112'd0, 8'd7, 8'd6}; regs = {112'd0, 8'd22, 8'd21};
    run_cmd(3'd2, 4'd4, 8'd0, 8'd2, ids, regs, 0, '0, c, il);
    set_reg(21, 32'd5); set_reg(22, 32'd5);
    run_cmd(3'd4, 4'd0, 8'd0, 8'd2, ids, regs, 32'd20, '0, c, il);
    @(negedge clk);
    chk("R4 just below reg", rf[21], 5);
    chk("R4 at threshold reg", rf[22], 6);
    read_slot(1'b0, 6, v); chk("R4 just below sem", v, 19);
    read_slot(1'b0, 7, v); chk("R4 at threshold sem", v, 21);
  endtask

  task automatic t_rep_ignored;
    int c; bit il; logic [31:0] v;
    run_cmd(3'd2, 4'd0, 8'd3, 8'd1, 128'd10, 128'd0, 0, '0, c, il);
    chk("R5 one pass cycles", 32'(c), 2);
    read_slot(1'b0, 10, v); chk("R5 one pass value", v, 1);
  endtask

  task automatic bad(input string req, input logic [2:0] m, input logic [3:0] u,
                     input logic [7:0] cnt, input logic [127:0] ids,
                     input logic [127:0] regs, input logic [87:0] rsvd);
    int c; bit il;
    run_cmd(m, u, 8'd0, cnt, ids, regs, 0, rsvd, c, il);
    chk({req, " flagged"}, 32'(il), 1);
    chk("R10 pulse cycle", 32'(c), 1);
    @(negedge clk);
    chk("R10 single pulse", 32'(illegal), 0);
    chk("R10 ready", 32'(cmd_ready), 1);
  endtask

  task automatic t_illegal;
    logic [31:0] v;
    set_reg(23, 32'hDEAD);
    set_reg(25, 32'h55);
    bad("R7 mode", 3'd5, 4'd4, 8'd1, 128'd8, 128'd23, '0);
    bad("R7 cnt zero", 3'd2, 4'd4, 8'd0, 128'd0, 128'd0, '0);
    bad("R7 cnt high", 3'd2, 4'd4, 8'd17, 128'd8, 128'd23, '0);
    bad("R7 add imm", 3'd2, 4'd5, 8'd1, 128'd8, 128'd23, '0);
    bad("R7 wr imm", 3'd2, 4'd7, 8'd1, 128'd8, 128'd23, '0);
    bad("R9 reserved", 3'd2, 4'd4, 8'd1, 128'd8, 128'd23, 88'h1 << 87);
    bad("R8 unused id", 3'd2, 4'd4, 8'd1, {112'd0, 8'd3, 8'd8}, 128'd23, '0);
    bad("R8 unused reg", 3'd2, 4'd4, 8'd1, 128'd8, {112'd0, 8'd1, 8'd23}, '0);
    bad("R8 duplicate", 3'd2, 4'd4, 8'd2, {112'd0, 8'd8, 8'd8}, {112'd0, 8'd24, 8'd23}, '0);
    bad("R8 id range", 3'd2, 4'd4, 8'd1, 128'd16, 128'd23, '0);
    bad("R8 reg range", 3'd2, 4'd4, 8'd1, 128'd8, 128'd32, '0);
    bad("R8 duplicate read", 3'd0, 4'd0, 8'd2, 128'd0, {112'd0, 8'd26, 8'd25}, '0);
    chk("R10 no register write", rf[25], 32'h55);
    read_slot(1'b0, 8, v); chk("R10 no slot write", v, 0);
  endtask

  task automatic t_busy;
    logic [127:0] ids, regs; int n; logic [31:0] v;
    ids = '0; regs = '0;
    for (int i = 0; i < 4; i++) begin ids[i*8 +: 8] = 8'(11 + i); regs[i*8 +: 8] = 8'(6); end
    @(negedge clk);
    cmd_mode = 3'd2; cmd_upd = 4'd4; cmd_rep = 0; cmd_cnt = 8'd4; cmd_ids = ids;
    cmd_regs = regs; cmd_rsvd = '0; cmd_valid = 1'b1;
    @(negedge clk);
    chk("R11 ready low", 32'(cmd_ready), 0);
    cmd_ids = 128'd9; cmd_regs = 128'd23; cmd_cnt = 8'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
    read_slot(1'b0, 9, v); chk("R11 busy command ignored", v, 0);
    read_slot(1'b0, 14, v); chk("R11 run completes", v, 7);
  endtask

  task automatic t_full;
    logic [127:0] ids, regs; int c; bit il;
    ids = '0; regs = '0;
    for (int s = 0; s < 16; s++) begin
      set_reg(s, 32'h1000 + 32'(s));
      ids[s*8 +: 8] = 8'(15 - s); regs[s*8 +: 8] = 8'(s);
    end
    run_cmd(3'd2, 4'd4, 8'd0, 8'd16, ids, regs, 0, '0, c, il);
    chk("R6 sixteen slot cycles", 32'(c), 17);
    for (int s = 0; s < 16; s++) begin ids[s*8 +: 8] = 8'(s); regs[s*8 +: 8] = 8'(16 + s); end
    run_cmd(3'd0, 4'd0, 8'd0, 8'd16, ids, regs, 0, '0, c, il);
    @(negedge clk);
    for (int s = 0; s < 16; s++) chk("R2 full read", rf[16 + s], 32'h1000 + 32'(15 - s));
  endtask

  initial begin
    for (int k = 0; k < 32; k++) rf[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_read();
    t_evt_split();
    t_types();
    t_cond();
    t_rep_ignored();
    t_illegal();
    t_busy();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule